// File: doc/BRIEF.md
# Prescaled 8-bit Timer/Counter

The block is an 8-bit up-counter that software can read and write. It counts one of two sources. The first is the instruction-cycle enable from the core clocking logic. The second is the edges on an external input pin, which are brought into the clock domain through a two-flop synchroniser. An 8-bit prescaler sits in front of the counter. It is owned either by the timer or by the watchdog path, and never by both at once. Software cannot read or write the prescaler count. The only way software affects it is indirectly, through a write to the count.

A write to the count takes effect on the next clock edge. After that write, incrementing is held off for two instruction cycles. When the count wraps from 0xFF to 0x00, a sticky overflow flag is raised. The flag is cleared through a dedicated input. The watchdog side feeds its raw ticks in and receives a divided tick stream back.

Top module: `pscl_timer`

## Requirements
- R1: Reset (synchronous, active high) leaves the count at 0x00, the overflow flag low and the control register reading 0x04: internal source, prescaler given to the watchdog, ratio field 0.
- R2: The control register layout is: bit 0 selects the source (0 = instruction-cycle enable, 1 = external pin); bit 1 selects the edge (0 = rising, 1 = falling); bit 2 selects the prescaler owner (0 = timer, 1 = watchdog); bits 5:3 hold the ratio r. Bits 7:6 always read as zero.
- R3: In internal mode with the prescaler given to the watchdog, the count rises by exactly one for every clock cycle in which the instruction-cycle enable is high. It does not move while that enable is low.
- R4: In external mode with the rising edge selected, a low-to-high change of the pin adds one to the count. The new value is visible after the third rising clock edge following the change. A high-to-low change adds nothing.
- R5: With the falling edge selected, only a high-to-low change of the pin adds one, with the same three-edge latency.
- R6: A count write loads the bus value on the next clock edge. It overrides any increment in that cycle.
- R7: The first two instruction cycles after a count write produce no increment. At 1:1 with a steady enable, the first increment lands on the third clock edge after the write edge.
- R8: With the prescaler owned by the timer, the count advances once every 2^(r+1) source ticks, giving ratios from 1:2 (r = 0) to 1:256 (r = 7). After a count write, the first advance comes on the 2^(r+1)-th unsuppressed tick.
- R9: When the prescaler is owned by the timer, a count write also clears the prescaler. Each ratio therefore restarts its phase from the write, whatever count the prescaler held before.
- R10: A wrap from 0xFF to 0x00 sets the overflow flag, which stays set until the clear input is high. When a wrap and a clear fall in the same cycle, the set wins. Writing a value to the count never sets the flag.
- R11: The watchdog tick output pulses one clock after a watchdog input tick. It pulses once per 2^(r+1) input ticks when the watchdog owns the prescaler, and once per input tick otherwise.
- R12: Watchdog input ticks never change the timer count, whichever side owns the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Instruction-cycle enable, one clock wide per cycle |
| ext_pin | input | 1 | Asynchronous external count input |
| wdt_base_tick | input | 1 | Raw watchdog tick |
| bus_wr_cnt | input | 1 | Write strobe for the count |
| bus_wr_ctl | input | 1 | Write strobe for the control register |
| bus_wdata | input | DATA_W | Write data |
| ovf_clr | input | 1 | Clears the overflow flag |
| cnt_q | output | DATA_W | Current count |
| ctl_q | output | 8 | Control register read-back |
| ovf_flag | output | 1 | Sticky overflow flag |
| wdt_tick | output | 1 | Divided or passed-through watchdog tick |

## Verification
Every result has a fixed latency, and each check is timed to it:
- A count write is visible one edge after its strobe.
- At 1:1, the first increment after a write appears three edges after the write edge. With the prescaler, it appears 2 + 2^(r+1) edges after the write edge.
- A pin change shows in the count three edges later.
- The overflow flag rises on the same edge that produces 0x00.
- The watchdog tick follows its input tick by one edge.

Inputs are driven and outputs are sampled on falling clock edges. Each check waits a counted number of falling edges after its stimulus, so the expected value is computed from the edge count alone. The checks on external edges sample both two and three edges after the pin change. This confirms the count moves on exactly the third edge.

// File: rtl/tmrx_pkg.sv
package tmrx_pkg;

  typedef struct packed {
    logic [1:0] rsvd;
    logic [2:0] ratio;
    logic       to_wdt;
    logic       edge_fall;
    logic       src_ext;
  } tmrx_ctl_t;

  localparam tmrx_ctl_t CTL_RST = '{rsvd: 2'b00, ratio: 3'd0, to_wdt: 1'b1,
                                    edge_fall: 1'b0, src_ext: 1'b0};

endpackage

// File: rtl/tmrx_edge_sync.sv
module tmrx_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  // stages [SYNC_STAGES-1:0] synchronise, the top bit holds the previous value
  logic [SYNC_STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[SYNC_STAGES-1:0], pin_i};
  end

  always_comb begin
    rise_o = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];
    fall_o = ~shreg[SYNC_STAGES-1] & shreg[SYNC_STAGES];
  end
endmodule

// File: rtl/tmrx_prescale.sv
module tmrx_prescale #(
  parameter int PSC_W   = 8,
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_i,
  input  logic               tick_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               hit_o
);
  localparam int SH_W = RATIO_W + 1;

  logic [PSC_W-1:0] pcnt;
  logic [SH_W-1:0]  shamt;
  logic [PSC_W:0]   span;
  logic [PSC_W-1:0] mask;

  always_comb begin
    shamt = {1'b0, ratio_i} + SH_W'(1);
    span  = (PSC_W+1)'(1) << shamt;
    mask  = PSC_W'(span - (PSC_W+1)'(1));
    hit_o = tick_i && ((pcnt & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) pcnt <= '0;
    else if (tick_i)  pcnt <= pcnt + PSC_W'(1);
  end
endmodule

// File: rtl/tmrx_count.sv
module tmrx_count #(
  parameter int DATA_W    = 8,
  parameter int STALL_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              inc_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ovf_clr_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              ovf_o,
  output logic              hold_o
);
  localparam int ST_W = $clog2(STALL_CYC + 1);

  logic [ST_W-1:0] stall;
  logic            wrap;

  always_comb begin
    hold_o = (stall != '0);
    wrap   = inc_i && !wr_i && (cnt_o == {DATA_W{1'b1}});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stall <= '0;
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else begin
      if (wr_i)                         stall <= ST_W'(STALL_CYC);
      else if (tick_en && stall != '0)  stall <= stall - ST_W'(1);

      if (wr_i)       cnt_o <= wdata_i;
      else if (inc_i) cnt_o <= cnt_o + DATA_W'(1);

      if (wrap)           ovf_o <= 1'b1;
      else if (ovf_clr_i) ovf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pscl_timer.sv
module pscl_timer
  import tmrx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int PSC_W       = 8,
  parameter int STALL_CYC   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              ext_pin,
  input  logic              wdt_base_tick,
  input  logic              bus_wr_cnt,
  input  logic              bus_wr_ctl,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              ovf_clr,
  output logic [DATA_W-1:0] cnt_q,
  output logic [7:0]        ctl_q,
  output logic              ovf_flag,
  output logic              wdt_tick
);
  localparam int RATIO_W = 3;

  tmrx_ctl_t ctl;
  logic      pin_rise, pin_fall;
  logic      src_tick, gated_tick, hold;
  logic      psc_in, psc_clr, psc_hit, inc;

  always_ff @(posedge clk) begin
    if (rst)             ctl <= CTL_RST;
    else if (bus_wr_ctl) ctl <= tmrx_ctl_t'({2'b00, bus_wdata[5:0]});
  end

  tmrx_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (ext_pin),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  always_comb begin
    src_tick   = ctl.src_ext ? (ctl.edge_fall ? pin_fall : pin_rise) : tick_en;
    gated_tick = src_tick && !hold;
    psc_in     = ctl.to_wdt ? wdt_base_tick : gated_tick;
    psc_clr    = bus_wr_cnt && !ctl.to_wdt;
    inc        = ctl.to_wdt ? gated_tick : psc_hit;
  end

  tmrx_prescale #(.PSC_W(PSC_W), .RATIO_W(RATIO_W)) u_psc (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (psc_clr),
    .tick_i  (psc_in),
    .ratio_i (ctl.ratio),
    .hit_o   (psc_hit)
  );

  tmrx_count #(.DATA_W(DATA_W), .STALL_CYC(STALL_CYC)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick_en   (tick_en),
    .inc_i     (inc),
    .wr_i      (bus_wr_cnt),
    .wdata_i   (bus_wdata),
    .ovf_clr_i (ovf_clr),
    .cnt_o     (cnt_q),
    .ovf_o     (ovf_flag),
    .hold_o    (hold)
  );

  always_ff @(posedge clk) begin
    if (rst) wdt_tick <= 1'b0;
    else     wdt_tick <= ctl.to_wdt ? psc_hit : wdt_base_tick;
  end

  assign ctl_q = ctl;
endmodule

// File: rtl/pscl_timer_chk.sv
module pscl_timer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr_cnt,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              ovf_clr,
  input logic [DATA_W-1:0] cnt_q,
  input logic [7:0]        ctl_q,
  input logic              ovf_flag
);
  assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cnt_q == '0 && !ovf_flag && ctl_q == 8'h04));

  assert_load_R6: assert property (@(posedge clk) disable iff (rst)
    $past(bus_wr_cnt) |-> cnt_q == $past(bus_wdata));

  assert_hold_first_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_wr_cnt) && !bus_wr_cnt) |=> $stable(cnt_q));

  assert_hold_second_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_wr_cnt, 2) && !$past(bus_wr_cnt) && !bus_wr_cnt) |=> $stable(cnt_q));

  assert_step_one_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(bus_wr_cnt) && cnt_q != $past(cnt_q)) |-> cnt_q == $past(cnt_q) + DATA_W'(1));

  assert_wrap_sets_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(bus_wr_cnt) && $past(cnt_q) == {DATA_W{1'b1}} && cnt_q == '0) |-> ovf_flag);

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(ovf_flag) && !$past(ovf_clr)) |-> ovf_flag);
endmodule

bind pscl_timer pscl_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr_cnt (bus_wr_cnt),
  .bus_wdata  (bus_wdata),
  .ovf_clr    (ovf_clr),
  .cnt_q      (cnt_q),
  .ctl_q      (ctl_q),
  .ovf_flag   (ovf_flag)
);

// File: tb/pscl_timer_tb_top.sv
module pscl_timer_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0, ext_pin = 1'b0, wdt_base_tick = 1'b0;
  logic       bus_wr_cnt = 1'b0, bus_wr_ctl = 1'b0, ovf_clr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] cnt_q, ctl_q;
  logic       ovf_flag, wdt_tick;
  int         total = 0;
  int         bad = 0;

  always #4 clk = ~clk;

  pscl_timer dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .ext_pin(ext_pin),
    .wdt_base_tick(wdt_base_tick), .bus_wr_cnt(bus_wr_cnt), .bus_wr_ctl(bus_wr_ctl),
    .bus_wdata(bus_wdata), .ovf_clr(ovf_clr), .cnt_q(cnt_q), .ctl_q(ctl_q),
    .ovf_flag(ovf_flag), .wdt_tick(wdt_tick)
  );

  // {control, value written to count, clock edges waited after the write edge}
  localparam logic [31:0] VEC [0:13] = '{
    {8'h04, 8'h00, 16'd1},   {8'h04, 8'h10, 16'd2},  {8'h04, 8'h10, 16'd3},
    {8'h04, 8'h20, 16'd12},  {8'h00, 8'h30, 16'd11}, {8'h00, 8'h30, 16'd3},
    {8'h08, 8'h40, 16'd18},  {8'h08, 8'h40, 16'd5},  {8'h08, 8'h40, 16'd6},
    {8'h38, 8'h00, 16'd300}, {8'h10, 8'hFE, 16'd26}, {8'h04, 8'hFD, 16'd10},
    {8'h04, 8'hFF, 16'd2},   {8'h20, 8'h7F, 16'd66}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_ctl(input logic [7:0] v);
    bus_wr_ctl = 1'b1; bus_wdata = v;
    @(negedge clk);
    bus_wr_ctl = 1'b0;
  endtask

  task automatic write_cnt(input logic [7:0] v, input logic clr);
    bus_wr_cnt = 1'b1; bus_wdata = v; ovf_clr = clr;
    @(negedge clk);
    bus_wr_cnt = 1'b0; ovf_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL timeout actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 count", cnt_q, 8'h00);
    check("R1 flag", ovf_flag, 0);
    check("R1 control", ctl_q, 8'h04);

    // R6 R7 R8 R9 R10 R12: vector walk, watchdog ticks running throughout
    tick_en = 1'b1;
    wdt_base_tick = 1'b1;
    for (int i = 0; i < 14; i++) begin
      int d, incs, sum;
      write_ctl(VEC[i][31:24]);
      write_cnt(VEC[i][23:16], 1'b1);
      repeat (int'(VEC[i][15:0])) @(negedge clk);
      d    = VEC[i][26] ? 1 : (1 << (int'(VEC[i][29:27]) + 1));
      incs = (VEC[i][15:0] >= 2) ? (int'(VEC[i][15:0]) - 2) / d : 0;
      sum  = int'(VEC[i][23:16]) + incs;
      check($sformatf("R7 R8 R9 R12 vector %0d count", i), cnt_q, sum % 256);
      check($sformatf("R10 vector %0d flag", i), ovf_flag, (sum > 255) ? 1 : 0);
    end
    wdt_base_tick = 1'b0;

    // R2 field read-back
    write_ctl(8'hFF);
    check("R2 reserved bits read zero", ctl_q, 8'h3F);

    // R3 enable gating at 1:1
    write_ctl(8'h04);
    write_cnt(8'h50, 1'b1);
    repeat (3) @(negedge clk);
    check("R3 one step", cnt_q, 8'h51);
    tick_en = 1'b0;
    repeat (5) @(negedge clk);
    check("R3 enable low holds", cnt_q, 8'h51);
    tick_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 enable high counts", cnt_q, 8'h54);

    // R10 set beats clear, then clear
    write_cnt(8'hFE, 1'b1);
    repeat (3) @(negedge clk);
    check("R10 at FF", cnt_q, 8'hFF);
    ovf_clr = 1'b1;
    @(negedge clk);
    check("R10 wrap count", cnt_q, 8'h00);
    check("R10 set wins over clear", ovf_flag, 1);
    @(negedge clk);
    ovf_clr = 1'b0;
    check("R10 clear", ovf_flag, 0);

    // R4 rising edge counting
    write_ctl(8'h05);
    write_cnt(8'h10, 1'b1);
    repeat (3) @(negedge clk);
    ext_pin = 1'b1;
    repeat (2) @(negedge clk);
    check("R4 not before third edge", cnt_q, 8'h10);
    @(negedge clk);
    check("R4 rise counted", cnt_q, 8'h11);
    ext_pin = 1'b0;
    repeat (4) @(negedge clk);
    check("R4 fall ignored", cnt_q, 8'h11);

    // R5 falling edge counting
    write_ctl(8'h07);
    ext_pin = 1'b1;
    repeat (4) @(negedge clk);
    check("R5 rise ignored", cnt_q, 8'h11);
    ext_pin = 1'b0;
    repeat (2) @(negedge clk);
    check("R5 not before third edge", cnt_q, 8'h11);
    @(negedge clk);
    check("R5 fall counted", cnt_q, 8'h12);

    // R11 R12 watchdog path, timer idle
    tick_en = 1'b0;
    for (int pass = 0; pass < 2; pass++) begin
      int pulses;
      pulses = 0;
      write_ctl(pass == 0 ? 8'h0C : 8'h08);
      for (int k = 0; k < 20; k++) begin
        wdt_base_tick = (k < 16);
        @(negedge clk);
        if (wdt_tick) pulses++;
      end
      check(pass == 0 ? "R11 divided by four" : "R11 passed through", pulses, pass == 0 ? 4 : 16);
      check("R12 timer untouched by watchdog ticks", cnt_q, 8'h12);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule